// File: doc/BRIEF.md
# Convolution Tile Sequencer for a Weight-Stationary Crossbar

This block turns one convolution layer into an ordered command stream for a crossbar of fixed size. Kernel height and width, input and output channel counts and the output map size arrive as configuration, sampled on a start pulse. The kernel depth is flattened down the crossbar rows, and output channels go across the columns. Rows are filled a whole input channel (kernel height × width entries) at a time, so a crossbar may be left partly filled. The idle rows show up in a utilization pair reported when the layer finishes.

For every weight tile the sequencer first issues one load command per used row. It then walks every output pixel. For each pixel it issues the input fetch coordinates, then one accumulate command. After the last row tile of a column group it also issues a writeback for that pixel. A tile stays resident until every pixel has used it. The column groups form the outer loop and the row tiles the inner loop. The block issues one command per cycle, with no back-pressure.

Top module: `map_seq`

## Requirements
- R1: After reset, and whenever no layer is running, busy_o, done_o, cmd_valid_o and err_o are 0.
- R2: Each weight tile opens with one load command (op code 0) per used row. It carries a = kernel row, b = kernel column, ch = absolute input channel and oc = column-group base. The kernel column steps fastest, then the kernel row, then the channel.
- R3: Channels per row tile = floor(ROWS/(R·S)), and the final tile takes the remaining channels. Column groups step by COLS over the output channels and form the outer loop, with the row tiles nested inside each group.
- R4: After the loads of a tile, the output pixels are visited in raster order (column fastest). Each pixel issues fetch commands (op code 1) with a = e+r, b = f+s and ch = c, in the same order as the loads.
- R5: After each pixel's fetches, one accumulate command (op code 2) is issued with a = e, b = f and ch = the tile's first channel.
- R6: A writeback command (op code 3) with the same fields follows the accumulate only in the last row tile of a column group.
- R7: No load command appears between a tile's first fetch and its last pixel; the next tile loads only after all pixels are done.
- R8: If R·S exceeds ROWS, or any dimension is 0, the layer ends with done_o one cycle after start, err_o = 1, no commands and zero utilization. err_o holds until the next accepted start.
- R9: busy_o rises the cycle after an accepted start and stays high through the done_o cycle. done_o is a single-cycle pulse that follows the last command.
- R10: At done_o, util_used_o is the sum of the used rows over all accumulate commands, and util_total_o is ROWS times their number. Both hold until the next accepted start.
- R11: A start pulse while busy_o is 1 is ignored, and so are configuration changes during that time. The running stream is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| k_rows_i | input | KW | Kernel height R |
| k_cols_i | input | KW | Kernel width S |
| in_ch_i | input | CW | Input channels C |
| out_ch_i | input | MW | Output channels M |
| out_h_i | input | PW | Output height E |
| out_w_i | input | PW | Output width F |
| busy_o | output | 1 | Layer in progress |
| done_o | output | 1 | Layer finished pulse |
| err_o | output | 1 | Last accepted configuration was invalid |
| cmd_valid_o | output | 1 | Command present this cycle |
| cmd_op_o | output | 2 | 0 load, 1 fetch, 2 accumulate, 3 writeback |
| cmd_a_o | output | PW+1 | Row coordinate (kernel row or input row or output row) |
| cmd_b_o | output | PW+1 | Column coordinate |
| cmd_ch_o | output | CW | Input channel |
| cmd_oc_o | output | MW | Output-channel base of the column group |
| util_used_o | output | UW | Used row slots over the layer |
| util_total_o | output | UW | Available row slots over the layer |

## Verification
Every counter in the sequencer feeds a command field directly. A wrong kernel, channel or pixel index therefore shows up as a wrong coordinate in the very cycle it goes wrong. A wrong wrap or tile boundary shows up as a wrong op code one cycle later. The bench compares every command cycle by cycle against a stream it builds itself, so a derailed state machine is caught at its first bad command. Wrong tile sizing shows up twice: in the number of loads and fetches, and in the utilization pair at done.

// File: rtl/map_pkg.sv
package map_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_FETCH = 2'd1, OP_ACC = 2'd2, OP_WB = 2'd3} map_op_e;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_FETCH, S_ACC, S_WB, S_DONE} map_st_e;
endpackage

// File: rtl/map_cfg.sv
module map_cfg #(
  parameter int KW = 4,
  parameter int CW = 8,
  parameter int MW = 8,
  parameter int PW = 8,
  parameter int ROWS = 16
) (
  input  logic [KW-1:0]   r_i,
  input  logic [KW-1:0]   s_i,
  input  logic [CW-1:0]   c_i,
  input  logic [MW-1:0]   m_i,
  input  logic [PW-1:0]   e_i,
  input  logic [PW-1:0]   f_i,
  output logic [2*KW-1:0] rs_o,
  output logic [CW-1:0]   cpt_o,
  output logic            err_o
);
  always_comb begin
    rs_o  = (2*KW)'(r_i) * (2*KW)'(s_i);
    cpt_o = (rs_o == '0) ? '0 : CW'(32'(ROWS) / 32'(rs_o));
    err_o = (r_i == '0) || (s_i == '0) || (c_i == '0) || (m_i == '0) ||
            (e_i == '0) || (f_i == '0) || (32'(rs_o) > 32'(ROWS));
  end
endmodule

// File: rtl/map_walk.sv
module map_walk
  import map_pkg::*;
#(
  parameter int KW = 4,
  parameter int CW = 8,
  parameter int MW = 8,
  parameter int PW = 8,
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int AW = PW + 1,
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic            err_go_i,
  input  logic [KW-1:0]   r_i,
  input  logic [KW-1:0]   s_i,
  input  logic [CW-1:0]   c_i,
  input  logic [MW-1:0]   m_i,
  input  logic [PW-1:0]   e_i,
  input  logic [PW-1:0]   f_i,
  input  logic [2*KW-1:0] rs_i,
  input  logic [CW-1:0]   cpt_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fin_o,
  output logic            acc_o,
  output logic [RW-1:0]   trows_o,
  output logic            valid_o,
  output logic [1:0]      op_o,
  output logic [AW-1:0]   a_o,
  output logic [AW-1:0]   b_o,
  output logic [CW-1:0]   ch_o,
  output logic [MW-1:0]   oc_o
);
  map_st_e st;
  logic [MW-1:0] ob;
  logic [CW-1:0] cb, cl, cl_n, rem, nt;
  logic [KW-1:0] kr, ks, kr_n, ks_n;
  logic [PW-1:0] pe, pf, pe_n, pf_n;
  logic k_last, px_last, rt_last, ct_last;

  always_comb begin
    rem     = c_i - cb;
    nt      = (rem < cpt_i) ? rem : cpt_i;
    rt_last = ({1'b0, cb} + {1'b0, nt}) >= {1'b0, c_i};
    ct_last = ({1'b0, ob} + (MW+1)'(COLS)) >= {1'b0, m_i};
    trows_o = RW'(32'(nt) * 32'(rs_i));
    k_last  = (cl == nt - CW'(1)) && (kr == r_i - KW'(1)) && (ks == s_i - KW'(1));
    px_last = (pe == e_i - PW'(1)) && (pf == f_i - PW'(1));
    // kernel walk: column fastest, then row, then channel
    ks_n = ks + KW'(1); kr_n = kr; cl_n = cl;
    if (ks == s_i - KW'(1)) begin
      ks_n = '0;
      kr_n = kr + KW'(1);
      if (kr == r_i - KW'(1)) begin
        kr_n = '0;
        cl_n = cl + CW'(1);
      end
    end
    if (k_last) begin ks_n = '0; kr_n = '0; cl_n = '0; end
    pf_n = pf + PW'(1); pe_n = pe;
    if (pf == f_i - PW'(1)) begin pf_n = '0; pe_n = pe + PW'(1); end
    if (px_last) begin pf_n = '0; pe_n = '0; end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; ob <= '0; cb <= '0; cl <= '0;
      kr <= '0; ks <= '0; pe <= '0; pf <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (go_i) begin
          ob <= '0; cb <= '0; cl <= '0; kr <= '0; ks <= '0; pe <= '0; pf <= '0;
          st <= err_go_i ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          cl <= cl_n; kr <= kr_n; ks <= ks_n;
          if (k_last) st <= S_FETCH;
        end
        S_FETCH: begin
          cl <= cl_n; kr <= kr_n; ks <= ks_n;
          if (k_last) st <= S_ACC;
        end
        S_ACC, S_WB: begin
          if (st == S_ACC && rt_last) st <= S_WB;
          else begin
            pe <= pe_n; pf <= pf_n;
            if (!px_last) st <= S_FETCH;
            else if (!rt_last) begin cb <= cb + nt; st <= S_LOAD; end
            else if (!ct_last) begin cb <= '0; ob <= ob + MW'(COLS); st <= S_LOAD; end
            else st <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o  = (st != S_IDLE);
    done_o  = (st == S_DONE);
    acc_o   = (st == S_ACC);
    fin_o   = (st == S_IDLE && go_i && err_go_i) ||
              (st == S_WB && px_last && ct_last);
    valid_o = (st == S_LOAD) || (st == S_FETCH) || (st == S_ACC) || (st == S_WB);
    oc_o    = ob;
    unique case (st)
      S_LOAD:  begin op_o = OP_LOAD;  a_o = AW'(kr); b_o = AW'(ks); ch_o = cb + cl; end
      S_FETCH: begin op_o = OP_FETCH; a_o = AW'(pe) + AW'(kr); b_o = AW'(pf) + AW'(ks); ch_o = cb + cl; end
      S_WB:    begin op_o = OP_WB;    a_o = AW'(pe); b_o = AW'(pf); ch_o = cb; end
      default: begin op_o = OP_ACC;   a_o = AW'(pe); b_o = AW'(pf); ch_o = cb; end
    endcase
  end
endmodule

// File: rtl/map_util.sv
module map_util #(
  parameter int RW = 5,
  parameter int UW = 24,
  parameter int ROWS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          acc_i,
  input  logic          fin_i,
  input  logic [RW-1:0] trows_i,
  output logic [UW-1:0] used_o,
  output logic [UW-1:0] total_o
);
  logic [UW-1:0] used_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0; total_q <= '0; used_o <= '0; total_o <= '0;
    end else if (go_i) begin
      used_q <= '0; total_q <= '0; used_o <= '0; total_o <= '0;
    end else begin
      if (acc_i) begin
        used_q  <= used_q + UW'(trows_i);
        total_q <= total_q + UW'(ROWS);
      end
      if (fin_i) begin
        used_o  <= used_q;
        total_o <= total_q;
      end
    end
  end
endmodule

// File: rtl/map_seq.sv
module map_seq #(
  parameter int KW = 4,
  parameter int CW = 8,
  parameter int MW = 8,
  parameter int PW = 8,
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int UW = 24,
  localparam int AW = PW + 1,
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] k_rows_i,
  input  logic [KW-1:0] k_cols_i,
  input  logic [CW-1:0] in_ch_i,
  input  logic [MW-1:0] out_ch_i,
  input  logic [PW-1:0] out_h_i,
  input  logic [PW-1:0] out_w_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [AW-1:0] cmd_a_o,
  output logic [AW-1:0] cmd_b_o,
  output logic [CW-1:0] cmd_ch_o,
  output logic [MW-1:0] cmd_oc_o,
  output logic [UW-1:0] util_used_o,
  output logic [UW-1:0] util_total_o
);
  logic [2*KW-1:0] rs_w, rs_q;
  logic [CW-1:0] cpt_w, cpt_q, c_q;
  logic [KW-1:0] r_q, s_q;
  logic [MW-1:0] m_q;
  logic [PW-1:0] e_q, f_q;
  logic err_w, go, fin, acc;
  logic [RW-1:0] trows;

  assign go = start_i && !busy_o;

  map_cfg #(.KW(KW), .CW(CW), .MW(MW), .PW(PW), .ROWS(ROWS)) u_cfg (
    .r_i(k_rows_i), .s_i(k_cols_i), .c_i(in_ch_i), .m_i(out_ch_i),
    .e_i(out_h_i), .f_i(out_w_i), .rs_o(rs_w), .cpt_o(cpt_w), .err_o(err_w)
  );

  // configuration frozen for the whole layer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0; s_q <= '0; c_q <= '0; m_q <= '0; e_q <= '0; f_q <= '0;
      rs_q <= '0; cpt_q <= '0; err_o <= 1'b0;
    end else if (go) begin
      r_q <= k_rows_i; s_q <= k_cols_i; c_q <= in_ch_i; m_q <= out_ch_i;
      e_q <= out_h_i; f_q <= out_w_i; rs_q <= rs_w; cpt_q <= cpt_w; err_o <= err_w;
    end
  end

  map_walk #(.KW(KW), .CW(CW), .MW(MW), .PW(PW), .ROWS(ROWS), .COLS(COLS)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .err_go_i(err_w),
    .r_i(r_q), .s_i(s_q), .c_i(c_q), .m_i(m_q), .e_i(e_q), .f_i(f_q),
    .rs_i(rs_q), .cpt_i(cpt_q),
    .busy_o(busy_o), .done_o(done_o), .fin_o(fin), .acc_o(acc), .trows_o(trows),
    .valid_o(cmd_valid_o), .op_o(cmd_op_o), .a_o(cmd_a_o), .b_o(cmd_b_o),
    .ch_o(cmd_ch_o), .oc_o(cmd_oc_o)
  );

  map_util #(.RW(RW), .UW(UW), .ROWS(ROWS)) u_util (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .acc_i(acc), .fin_i(fin),
    .trows_i(trows), .used_o(util_used_o), .total_o(util_total_o)
  );
endmodule

// File: rtl/map_seq_chk.sv
module map_seq_chk #(
  parameter int UW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          cmd_valid_o,
  input logic [1:0]    cmd_op_o,
  input logic [UW-1:0] util_used_o,
  input logic [UW-1:0] util_total_o
);
  // R9
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);
  // R9
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));
  // R11
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd0) |=> (cmd_valid_o && (cmd_op_o == 2'd0 || cmd_op_o == 2'd1)));
  // R7
  fetch_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd1) |=> (cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2)));
  // R6
  wb_after_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd3) |-> $past(cmd_valid_o && cmd_op_o == 2'd2));
  // R8
  err_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cmd_valid_o);
  // R10
  util_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(util_used_o) && $stable(util_total_o)));
  // R10
  util_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (util_used_o <= util_total_o));
endmodule

bind map_seq map_seq_chk #(.UW(UW)) u_chk (.*);

// File: tb/map_seq_bench.sv
`timescale 1ns/1ps
module map_seq_bench;
  localparam int ROWS = 16;
  localparam int COLS = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] kr = '0, ks = '0;
  logic [7:0] ci = '0, mo = '0, eh = '0, fw = '0;
  logic busy, done, err, cv;
  logic [1:0] op;
  logic [8:0] ca, cbb;
  logic [7:0] cch, coc;
  logic [23:0] used, total;
  int checks = 0, errors = 0, ncmd = 0;
  int cur_r, cur_f;
  bit inj = 0;

  always #2 clk = ~clk;

  map_seq u_map_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .k_rows_i(kr), .k_cols_i(ks),
    .in_ch_i(ci), .out_ch_i(mo), .out_h_i(eh), .out_w_i(fw),
    .busy_o(busy), .done_o(done), .err_o(err), .cmd_valid_o(cv), .cmd_op_o(op),
    .cmd_a_o(ca), .cmd_b_o(cbb), .cmd_ch_o(cch), .cmd_oc_o(coc),
    .util_used_o(used), .util_total_o(total)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // compare one command at the current negedge, then advance one cycle
  task automatic exp_cmd(string req, int eop, int ea, int eb, int ech, int eoc);
    checks++;
    if (!(cv === 1'b1 && int'(op) == eop && int'(ca) == ea && int'(cbb) == eb &&
          int'(cch) == ech && int'(coc) == eoc)) begin
      errors++;
      $display("FAIL %s: got v%0d op%0d a%0d b%0d ch%0d oc%0d expected op%0d a%0d b%0d ch%0d oc%0d",
               req, cv, op, ca, cbb, cch, coc, eop, ea, eb, ech, eoc);
    end
    ncmd++;
    if (inj && ncmd == 3) begin  // R11: start and config change while busy
      start = 1'b1; kr = 4'd1; fw = 8'd1;
    end
    @(negedge clk);
    start = 1'b0; kr = 4'(cur_r); fw = 8'(cur_f);
  endtask

  task automatic run_layer(int R, int S, int C, int M, int E, int F, bit do_inj);
    int rs, cpt, u, t;
    rs = R * S; cpt = ROWS / rs; u = 0; t = 0;
    cur_r = R; cur_f = F; inj = do_inj; ncmd = 0;
    @(negedge clk);
    kr = 4'(R); ks = 4'(S); ci = 8'(C); mo = 8'(M); eh = 8'(E); fw = 8'(F); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    chk("R8 err clear on valid cfg", int'(err), 0);
    for (int ob = 0; ob < M; ob += COLS) begin
      for (int cb = 0; cb < C; cb += cpt) begin
        int nt;
        bit lr;
        nt = (C - cb < cpt) ? C - cb : cpt;
        lr = (cb + nt >= C);
        for (int cl = 0; cl < nt; cl++)
          for (int r = 0; r < R; r++)
            for (int s = 0; s < S; s++)
              exp_cmd("R2 R3 load", 0, r, s, cb + cl, ob);
        for (int e = 0; e < E; e++)
          for (int f = 0; f < F; f++) begin
            for (int cl = 0; cl < nt; cl++)
              for (int r = 0; r < R; r++)
                for (int s = 0; s < S; s++)
                  exp_cmd("R4 R7 fetch", 1, e + r, f + s, cb + cl, ob);
            exp_cmd("R5 acc", 2, e, f, cb, ob);
            u += nt * rs; t += ROWS;
            if (lr) exp_cmd("R6 writeback", 3, e, f, cb, ob);
          end
      end
    end
    chk("R9 done pulse", int'(done), 1);
    chk("R9 busy in done cycle", int'(busy), 1);
    chk("R9 no cmd at done", int'(cv), 0);
    chk("R10 used rows", int'(used), u);
    chk("R10 total rows", int'(total), t);
    @(negedge clk);
    chk("R9 busy falls", int'(busy), 0);
    chk("R9 done single", int'(done), 0);
    @(negedge clk);
    chk("R10 used held", int'(used), u);
    chk("R10 total held", int'(total), t);
    inj = 0;
  endtask

  task automatic run_err(int R, int S, int C, int M, int E, int F);
    @(negedge clk);
    kr = 4'(R); ks = 4'(S); ci = 8'(C); mo = 8'(M); eh = 8'(E); fw = 8'(F); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done at once", int'(done), 1);
    chk("R8 err flag", int'(err), 1);
    chk("R8 no command", int'(cv), 0);
    chk("R8 util zero", int'(used) + int'(total), 0);
    @(negedge clk);
    chk("R8 idle after err", int'(busy), 0);
    chk("R8 err held", int'(err), 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 done idle", int'(done), 0);
    chk("R1 valid idle", int'(cv), 0);
    chk("R1 err idle", int'(err), 0);
    run_layer(3, 3, 3, 10, 2, 3, 1'b0);  // 9 of 16 rows, two column groups
    run_layer(1, 1, 20, 8, 2, 2, 1'b0);  // tiles of 16 and 4 channels
    run_layer(2, 2, 5, 3, 1, 2, 1'b1);   // R11 injection mid-stream
    run_err(5, 5, 1, 1, 1, 1);           // R*S over rows
    run_layer(4, 4, 2, 9, 2, 2, 1'b0);   // fully packed rows
    run_err(2, 2, 0, 4, 2, 2);           // zero channels
    run_layer(1, 2, 9, 17, 1, 1, 1'b0);  // three column groups, single pixel
    chk("R1 idle at end", int'(busy) + int'(cv) + int'(done), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule